// File: doc/BRIEF.md
# Analog Sample Ring Pointer Manager

This block is the digital controller for a switched-capacitor sample array that records without pause and is read out while recording carries on. A write pointer walks the storage cells as a ring, one cell per sample enable. When a trigger arrives, the controller takes the write position at that instant and subtracts the programmed trigger latency. The result is the first cell of the event. That start cell and the programmed window length go into a small queue of pending windows.

A readout sequencer takes the queued windows oldest first. It presents their cell addresses one per read strobe to an external digitizer and marks the last cell of each window. The write pointer may reach a cell that still belongs to a window that has not been read. In that case writing halts and an overflow flag is raised until the reader frees that cell. A trigger that finds the queue full is dropped and counted.

A valid configuration has a window length of at least 1 and no more than the latency, and a latency below the array depth. Every cell of a window has then been written before the trigger is seen.

Top module: `sca_ptr_mgr`

## Requirements
- R1: After reset `wr_addr` is 0, `overflow`, `busy` and `rd_valid` are 0 and `lost_cnt` is 0. `wr_addr` increases by one, modulo DEPTH (default 512), on each clock with `samp_en` high unless writing is halted, and holds while `samp_en` is low.
- R2: A trigger accepted in a cycle where `wr_addr` reads P creates a window. The window starts at cell (P − `trig_lat`) mod DEPTH and spans `win_len` consecutive cells, wrapping from DEPTH−1 to 0.
- R3: While `rd_valid` is high, `rd_addr` shows the next unread cell of the current window, and each clock with `rd_strobe` high moves it to the following cell. `rd_last` is high exactly while the final cell of the window is shown, so a one-cell window shows it on its only cell.
- R4: Windows are read out in trigger order. Up to QDEPTH (default 4) windows wait in the queue, plus the one under readout.
- R5: A trigger that arrives while the queue holds QDEPTH windows creates no window and increments `lost_cnt`. The counter saturates at its all-ones value.
- R6: When `samp_en` is high and the cell at `wr_addr` belongs to an unread window, `wr_addr` holds and `overflow` goes high. Both stay that way until that cell has been read, and writing then resumes.
- R7: Writing continues at one cell per enabled clock while a window is being read.
- R8: `busy` is high whenever a window is queued or under readout, and low otherwise.
- R9: `rd_strobe` while `rd_valid` is low has no effect on any later window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_en | input | 1 | Write one cell this cycle |
| trig | input | 1 | Event trigger, one cycle per event |
| trig_lat | input | AW | Cells between the window start and the write position at trigger |
| win_len | input | AW+1 | Cells kept per trigger |
| rd_strobe | input | 1 | Digitizer consumed the shown cell |
| wr_addr | output | AW | Cell written when `samp_en` is high |
| rd_valid | output | 1 | `rd_addr` holds a cell to read |
| rd_addr | output | AW | Cell to read |
| rd_last | output | 1 | Shown cell is the last of its window |
| busy | output | 1 | A window is pending or under readout |
| overflow | output | 1 | Writing halted by an unread cell |
| lost_cnt | output | LOSTW | Saturating count of dropped triggers |

## Verification
The bench places a window across the ring's top cell. A design with a wrong modulo or a latency applied with the wrong sign reads cells 509..511 and 0..1 wrongly. It runs the writer a full lap onto an unread window. A guard that misses the active window would overwrite that window, and a guard that frees cells in the wrong order would stay halted after the cells are read. It fills the queue and then keeps triggering. This exposes an off-by-one in the full test, windows served out of order, and a lost counter that wraps instead of saturating. Single-cell windows and strobes with nothing pending check the end-of-event flag and the idle sequencer.

// File: rtl/sca_pm_pkg.sv
package sca_pm_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/sca_wptr.sv
module sca_wptr #(
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          samp_en,
   input  logic          blocked,
   output logic [AW-1:0] wr_ptr,
   output logic          overflow
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         overflow <= 1'b0;
      end else begin
         if (samp_en && !blocked) wr_ptr <= wr_ptr + 1'b1;
         overflow <= blocked && (samp_en || overflow);
      end
   end
endmodule

// File: rtl/sca_winq.sv
module sca_winq #(
   parameter int AW     = 9,
   parameter int QDEPTH = 4,
   localparam int QAW   = $clog2(QDEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   push,
   input  logic [AW-1:0]          push_start,
   input  logic [AW:0]            push_len,
   input  logic                   pop,
   output logic                   empty,
   output logic                   full,
   output logic [AW-1:0]          head_start,
   output logic [AW:0]            head_len,
   output logic [QDEPTH*AW-1:0]   ent_start,
   output logic [QDEPTH*(AW+1)-1:0] ent_len,
   output logic [QDEPTH-1:0]      ent_vld
);
   logic [AW-1:0] st_q  [QDEPTH];
   logic [AW:0]   len_q [QDEPTH];
   logic [QAW-1:0] wp, rp;
   logic [QAW:0]   cnt;

   assign empty      = (cnt == '0);
   assign full       = (cnt == (QAW+1)'(QDEPTH));
   assign head_start = st_q[rp];
   assign head_len   = len_q[rp];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         for (int i = 0; i < QDEPTH; i++) begin
            st_q[i]  <= '0;
            len_q[i] <= '0;
         end
      end else begin
         if (push) begin
            st_q[wp]  <= push_start;
            len_q[wp] <= push_len;
            wp        <= wp + 1'b1;
         end
         if (pop) rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   for (genvar g = 0; g < QDEPTH; g++) begin : g_ent
      logic [QAW-1:0] rel;
      assign rel = QAW'(g) - rp;
      assign ent_vld[g] = ({1'b0, rel} < cnt);
      assign ent_start[g*AW +: AW]       = st_q[g];
      assign ent_len[g*(AW+1) +: (AW+1)] = len_q[g];
   end
endmodule

// File: rtl/sca_guard.sv
module sca_guard #(
   parameter int AW     = 9,
   parameter int QDEPTH = 4
) (
   input  logic [AW-1:0]            probe,
   input  logic [QDEPTH*AW-1:0]     ent_start,
   input  logic [QDEPTH*(AW+1)-1:0] ent_len,
   input  logic [QDEPTH-1:0]        ent_vld,
   input  logic                     act,
   input  logic [AW-1:0]            act_cur,
   input  logic [AW:0]              act_rem,
   output logic                     hit
);
   logic [QDEPTH-1:0] q_hit;
   logic [AW-1:0]     act_off;

   for (genvar g = 0; g < QDEPTH; g++) begin : g_cmp
      logic [AW-1:0] off;
      assign off      = probe - ent_start[g*AW +: AW];
      assign q_hit[g] = ent_vld[g] && ({1'b0, off} < ent_len[g*(AW+1) +: (AW+1)]);
   end

   assign act_off = probe - act_cur;
   assign hit     = (|q_hit) || (act && ({1'b0, act_off} < act_rem));
endmodule

// File: rtl/sca_rdseq.sv
module sca_rdseq
   import sca_pm_pkg::*;
#(
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          q_empty,
   input  logic [AW-1:0] head_start,
   input  logic [AW:0]   head_len,
   input  logic          rd_strobe,
   output logic          pop,
   output logic          rd_valid,
   output logic [AW-1:0] rd_addr,
   output logic          rd_last,
   output logic [AW:0]   remain
);
   seq_state_e state;

   assign pop      = (state == SEQ_IDLE) && !q_empty;
   assign rd_valid = (state == SEQ_RUN);
   assign rd_last  = rd_valid && (remain == (AW+1)'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         rd_addr <= '0;
         remain  <= '0;
      end else if (pop) begin
         state   <= SEQ_RUN;
         rd_addr <= head_start;
         remain  <= head_len;
      end else if (rd_valid && rd_strobe) begin
         rd_addr <= rd_addr + 1'b1;
         remain  <= remain - 1'b1;
         if (rd_last) state <= SEQ_IDLE;
      end
   end
endmodule

// File: rtl/sca_ptr_mgr.sv
module sca_ptr_mgr #(
   parameter int  DEPTH  = 512,
   parameter int  QDEPTH = 4,
   parameter int  LOSTW  = 8,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             samp_en,
   input  logic             trig,
   input  logic [AW-1:0]    trig_lat,
   input  logic [AW:0]      win_len,
   input  logic             rd_strobe,
   output logic [AW-1:0]    wr_addr,
   output logic             rd_valid,
   output logic [AW-1:0]    rd_addr,
   output logic             rd_last,
   output logic             busy,
   output logic             overflow,
   output logic [LOSTW-1:0] lost_cnt
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (QDEPTH < 2 || (QDEPTH & (QDEPTH - 1)) != 0) begin : g_bad_qdepth
      $error("QDEPTH must be a power of two of at least 2");
   end
   if (LOSTW < 1) begin : g_bad_lostw
      $error("LOSTW must be at least 1");
   end

   logic                     blocked, q_empty, q_full, pop, accept;
   logic [AW-1:0]            head_start;
   logic [AW:0]              head_len, remain;
   logic [QDEPTH*AW-1:0]     ent_start;
   logic [QDEPTH*(AW+1)-1:0] ent_len;
   logic [QDEPTH-1:0]        ent_vld;

   assign accept = trig && !q_full;
   assign busy   = rd_valid || !q_empty;

   sca_wptr #(.AW(AW)) u_wptr (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .blocked(blocked),
      .wr_ptr(wr_addr), .overflow(overflow)
   );

   sca_winq #(.AW(AW), .QDEPTH(QDEPTH)) u_winq (
      .clk(clk), .rst_n(rst_n), .push(accept),
      .push_start(wr_addr - trig_lat), .push_len(win_len), .pop(pop),
      .empty(q_empty), .full(q_full), .head_start(head_start), .head_len(head_len),
      .ent_start(ent_start), .ent_len(ent_len), .ent_vld(ent_vld)
   );

   sca_guard #(.AW(AW), .QDEPTH(QDEPTH)) u_guard (
      .probe(wr_addr), .ent_start(ent_start), .ent_len(ent_len), .ent_vld(ent_vld),
      .act(rd_valid), .act_cur(rd_addr), .act_rem(remain), .hit(blocked)
   );

   sca_rdseq #(.AW(AW)) u_rdseq (
      .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .head_start(head_start),
      .head_len(head_len), .rd_strobe(rd_strobe), .pop(pop), .rd_valid(rd_valid),
      .rd_addr(rd_addr), .rd_last(rd_last), .remain(remain)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) lost_cnt <= '0;
      else if (trig && q_full && (lost_cnt != '1)) lost_cnt <= lost_cnt + 1'b1;
   end
endmodule

// File: rtl/sca_ptr_mgr_chk.sv
module sca_ptr_mgr_chk #(
   parameter int AW    = 9,
   parameter int LOSTW = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             samp_en,
   input logic             trig,
   input logic             rd_strobe,
   input logic [AW-1:0]    wr_addr,
   input logic             rd_valid,
   input logic             rd_last,
   input logic             busy,
   input logic             overflow,
   input logic [LOSTW-1:0] lost_cnt
);
   // R1
   wptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (wr_addr == $past(wr_addr)) || (wr_addr == AW'($past(wr_addr) + 1'b1)));
   // R1
   wptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !samp_en |=> $stable(wr_addr));
   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !rd_strobe && !$past(rd_strobe)) |=> $stable(wr_addr));
   // R3
   last_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> rd_valid);
   // R5
   lost_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (lost_cnt == $past(lost_cnt)) || (lost_cnt == LOSTW'($past(lost_cnt) + 1'b1)));
   // R8
   busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> busy);
   // R8
   busy_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !busy) |=> busy);
endmodule

bind sca_ptr_mgr sca_ptr_mgr_chk #(.AW(AW), .LOSTW(LOSTW)) u_chk (
   .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .trig(trig), .rd_strobe(rd_strobe),
   .wr_addr(wr_addr), .rd_valid(rd_valid), .rd_last(rd_last), .busy(busy),
   .overflow(overflow), .lost_cnt(lost_cnt)
);

// File: tb/sim_sca_ptr_mgr.sv
module sim_sca_ptr_mgr;
   localparam int DEPTH = 512;
   localparam int AW    = 9;
   localparam int LOSTW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic samp_en = 1'b0, trig = 1'b0, rd_strobe = 1'b0;
   logic [AW-1:0] trig_lat = '0;
   logic [AW:0]   win_len = '0;
   logic [AW-1:0] wr_addr, rd_addr;
   logic rd_valid, rd_last, busy, overflow;
   logic [LOSTW-1:0] lost_cnt;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sca_ptr_mgr #(.DEPTH(DEPTH), .QDEPTH(4), .LOSTW(LOSTW)) u0 (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .trig(trig), .trig_lat(trig_lat),
      .win_len(win_len), .rd_strobe(rd_strobe), .wr_addr(wr_addr), .rd_valid(rd_valid),
      .rd_addr(rd_addr), .rd_last(rd_last), .busy(busy), .overflow(overflow),
      .lost_cnt(lost_cnt)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic fire(input int lat, input int len, output logic [AW-1:0] p);
      trig_lat = AW'(lat);
      win_len  = (AW+1)'(len);
      p = wr_addr;
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
   endtask

   task automatic read_event(input logic [AW-1:0] s, input int len, input string req);
      int w = 0;
      while (!rd_valid && w < 20) begin @(negedge clk); w++; end
      check(rd_valid, req, "rd_valid before event", int'(rd_valid), 1);
      for (int k = 0; k < len; k++) begin
         logic [AW-1:0] e;
         e = AW'(s + AW'(k));
         check(rd_addr == e, req, "rd_addr", int'(rd_addr), int'(e));
         check(rd_last == (k == len - 1), "R3", "rd_last", int'(rd_last), int'(k == len - 1));
         rd_strobe = 1'b1;
         @(negedge clk);
      end
      rd_strobe = 1'b0;
   endtask

   task automatic t_reset_wrap();
      logic [AW-1:0] p;
      rst_n = 1'b0; cycles(3); rst_n = 1'b1;
      check(wr_addr == 0, "R1", "wr_addr after reset", int'(wr_addr), 0);
      check(!overflow && !busy && !rd_valid, "R1", "flags after reset",
            int'({overflow, busy, rd_valid}), 0);
      check(lost_cnt == 0, "R1", "lost_cnt after reset", int'(lost_cnt), 0);
      samp_en = 1'b1; cycles(3); samp_en = 1'b0;
      check(wr_addr == 3, "R1", "wr_addr after 3 enables", int'(wr_addr), 3);
      cycles(5);
      check(wr_addr == 3, "R1", "wr_addr without enable", int'(wr_addr), 3);
      fire(6, 5, p);
      check(busy, "R8", "busy after trigger", int'(busy), 1);
      read_event(AW'(509), 5, "R2");
      cycles(1);
      check(!busy, "R8", "busy after drain", int'(busy), 0);
   endtask

   task automatic t_stream();
      logic [AW-1:0] p, w0;
      samp_en = 1'b1; cycles(30);
      fire(20, 8, p);
      while (!rd_valid) @(negedge clk);
      w0 = wr_addr;
      read_event(AW'(p - 20), 8, "R2");
      check(AW'(wr_addr - w0) == 8, "R7", "cells written during readout",
            int'(AW'(wr_addr - w0)), 8);
   endtask

   task automatic t_order();
      logic [AW-1:0] p0, p1, p2;
      fire(30, 4, p0); cycles(2);
      fire(12, 12, p1); cycles(2);
      fire(50, 1, p2); cycles(2);
      check(busy, "R8", "busy with queued windows", int'(busy), 1);
      read_event(AW'(p0 - 30), 4, "R4");
      read_event(AW'(p1 - 12), 12, "R4");
      read_event(AW'(p2 - 50), 1, "R4");
      cycles(2);
      check(!busy, "R8", "busy after queue drained", int'(busy), 0);
   endtask

   task automatic t_drop();
      logic [AW-1:0] ps [5];
      logic [AW-1:0] q;
      for (int i = 0; i < 7; i++) begin
         fire(40, 2, q);
         if (i < 5) ps[i] = q;
         cycles(1);
      end
      check(lost_cnt == 2, "R5", "lost_cnt after overfill", int'(lost_cnt), 2);
      for (int i = 0; i < 8; i++) begin fire(40, 2, q); cycles(1); end
      check(lost_cnt == 7, "R5", "lost_cnt saturated", int'(lost_cnt), 7);
      for (int i = 0; i < 5; i++) read_event(AW'(ps[i] - 40), 2, "R4");
      cycles(2);
      check(!busy, "R5", "dropped triggers left no window", int'(busy), 0);
   endtask

   task automatic t_overflow();
      logic [AW-1:0] p, s;
      fire(10, 5, p);
      s = AW'(p - 10);
      cycles(600);
      check(overflow, "R6", "overflow after lap", int'(overflow), 1);
      check(wr_addr == s, "R6", "wr_addr halted at window", int'(wr_addr), int'(s));
      check(rd_valid && rd_addr == s, "R6", "window still readable", int'(rd_addr), int'(s));
      rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
      cycles(3);
      check(wr_addr == AW'(s + 1), "R6", "wr_addr after one freed cell",
            int'(wr_addr), int'(AW'(s + 1)));
      check(overflow, "R6", "overflow held on next unread cell", int'(overflow), 1);
      read_event(AW'(s + 1), 4, "R6");
      cycles(5);
      check(!overflow, "R6", "overflow cleared", int'(overflow), 0);
      check(AW'(wr_addr - s) >= 5, "R6", "writing resumed", int'(AW'(wr_addr - s)), 5);
   endtask

   task automatic t_idle_strobe();
      logic [AW-1:0] p;
      rd_strobe = 1'b1; cycles(4); rd_strobe = 1'b0;
      check(!rd_valid && !busy, "R9", "idle strobe left sequencer idle",
            int'({rd_valid, busy}), 0);
      fire(8, 3, p);
      read_event(AW'(p - 8), 3, "R9");
   endtask

   initial begin
      cycles(1);
      t_reset_wrap();
      t_stream();
      t_order();
      t_drop();
      t_overflow();
      t_idle_strobe();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule